// File: doc/BRIEF.md
# Flash Window Segment Decoder

This block maps bus addresses onto the chip selects of a flash controller. A fixed flash memory window starts at a base address set by a parameter. Each of the chip selects, four by default, owns one segment register. That register places an address window for the chip select inside the flash window, at 64 KB granularity. For every address on the bus, the block raises one chip-select hit, or it raises a miss flag when no enabled window claims the address.

Software loads the segment registers through a single-cycle write port. It reads them back through a combinational read port. The block also reports the decoded absolute base and byte size of every window, so that neighbouring logic can check or display the layout. Decoding is purely combinational from the stored registers. A new register value is therefore seen by the decoder in the cycle after the write edge.

Top module: `flash_seg_decoder`

## Requirements
- R1: After reset, segment register 0 reads 0x07FF0000, segment register 1 reads 0x0FFF0800, and every other segment register reads 0. The first two windows therefore cover offsets 0 to 128 MB and 128 MB to 256 MB.
- R2: Register bits [15:0] hold the first 64 KB unit of the window, which is offset bits [31:16]. Bits [31:16] hold the last 64 KB unit, inclusive. An offset in the flash window matches a segment when start*64K <= offset <= end*64K + 0xFFFF.
- R3: A segment register equal to zero disables its chip select. That chip select never hits, its reported size is 0, and its reported base equals the flash window base.
- R4: For an enabled segment, the reported base is the flash base plus start*64K. The reported size is (end + 1 - start)*64K bytes.
- R5: cs_hit has at most one bit set. When enabled segments overlap, the lowest chip-select index wins.
- R6: cs_miss is 1 and cs_hit is 0 in two cases: the address lies below the flash base or at or beyond the flash base plus the window span, or no enabled segment matches. Otherwise cs_miss is 0.
- R7: A write updates the addressed register at the clock edge. In the write cycle itself, decoding and readback still use the old value. From the next cycle on, readback returns the written word and decoding uses it.
- R8: A nonzero register whose end unit is below its start unit matches no address, and its reported size is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Write strobe for a segment register |
| reg_wr_idx | input | 2 | Chip-select index of the register written |
| reg_wr_data | input | 32 | Segment word to store |
| reg_rd_idx | input | 2 | Chip-select index of the register read |
| reg_rd_data | output | 32 | Stored segment word (combinational) |
| bus_addr | input | 32 | Absolute bus address to decode |
| cs_hit | output | 4 | One-hot chip-select hit |
| cs_miss | output | 1 | No enabled segment claims the address |
| win_base | output | 128 | Absolute base of each window, 32 bits per chip select |
| win_size | output | 132 | Byte size of each window, 33 bits per chip select |

## Verification
A register write and a decode of an address that the write affects can fall in the same cycle. To provoke this, the bench drives a write to a disabled segment and an address inside its future window during the same clock period. Before the edge, the bench expects a miss and the old readback. After the edge, it expects the hit on that chip select. The same timing is covered by a readback property in the bound checker. Overlap priority is checked in a separate case: a later segment is written over an earlier one, and the later one must win only after the earlier one has been cleared.

// File: rtl/flash_seg_pkg.sv
package flash_seg_pkg;

    localparam int DEF_ADDR_W     = 32;
    localparam int DEF_UNIT_SHIFT = 16;
    localparam int DEF_NUM_CS     = 4;

    // Reset word for chip select idx: the first n_rst selects get back-to-back
    // windows of units_per 64 KB units; the rest are disabled.
    function automatic logic [63:0] seg_reset_word(input int idx, input int units_per,
                                                   input int n_rst, input int field_w);
        logic [63:0] lo;
        logic [63:0] hi;
        if (idx >= n_rst) begin
            return 64'd0;
        end
        lo = 64'(idx * units_per);
        hi = lo + 64'(units_per) - 64'd1;
        return (hi << field_w) | lo;
    endfunction

endpackage

// File: rtl/seg_reg_file.sv
module seg_reg_file #(
    parameter int NUM_CS    = 4,
    parameter int FIELD_W   = 16,
    parameter int RST_UNITS = 2048,
    parameter int RST_SEGS  = 2,
    localparam int REG_W    = 2 * FIELD_W,
    localparam int IDX_W    = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_idx,
    input  logic [REG_W-1:0]        wr_data,
    input  logic [IDX_W-1:0]        rd_idx,
    output logic [REG_W-1:0]        rd_data,
    output logic [NUM_CS*REG_W-1:0] regs_flat
);
    import flash_seg_pkg::*;

    logic [REG_W-1:0] seg_q [NUM_CS];

    for (genvar g = 0; g < NUM_CS; g++) begin : g_seg
        localparam logic [REG_W-1:0] RST_VAL =
            REG_W'(seg_reset_word(g, RST_UNITS, RST_SEGS, FIELD_W));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                seg_q[g] <= RST_VAL;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                seg_q[g] <= wr_data;
            end
        end

        assign regs_flat[g*REG_W +: REG_W] = seg_q[g];
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_CS; i++) begin
            if (rd_idx == IDX_W'(i)) begin
                rd_data = seg_q[i];
            end
        end
    end
endmodule

// File: rtl/seg_window_calc.sv
module seg_window_calc #(
    parameter int ADDR_W     = 32,
    parameter int UNIT_SHIFT = 16,
    parameter logic [ADDR_W-1:0] FLASH_BASE = 32'h2000_0000,
    localparam int FIELD_W   = ADDR_W - UNIT_SHIFT,
    localparam int REG_W     = 2 * FIELD_W,
    localparam int SIZE_W    = ADDR_W + 1
) (
    input  logic [REG_W-1:0]  seg_word,
    output logic              seg_valid,
    output logic [ADDR_W-1:0] lo_off,
    output logic [ADDR_W-1:0] hi_off,
    output logic [ADDR_W-1:0] abs_base,
    output logic [SIZE_W-1:0] byte_size
);
    logic [FIELD_W-1:0] start_u;
    logic [FIELD_W-1:0] last_u;
    logic [FIELD_W:0]   unit_cnt;
    logic               ordered;

    assign start_u  = seg_word[FIELD_W-1:0];
    assign last_u   = seg_word[REG_W-1:FIELD_W];
    assign ordered  = (last_u >= start_u);
    assign seg_valid = (seg_word != '0) && ordered;

    assign lo_off   = {start_u, {UNIT_SHIFT{1'b0}}};
    assign hi_off   = {last_u, {UNIT_SHIFT{1'b1}}};
    assign unit_cnt = {1'b0, last_u} + {{FIELD_W{1'b0}}, 1'b1} - {1'b0, start_u};

    always_comb begin
        if (seg_word == '0) begin
            abs_base = FLASH_BASE;
        end else begin
            abs_base = FLASH_BASE + lo_off;
        end
        if (seg_valid) begin
            byte_size = {unit_cnt, {UNIT_SHIFT{1'b0}}};
        end else begin
            byte_size = '0;
        end
    end
endmodule

// File: rtl/seg_hit_select.sv
module seg_hit_select #(
    parameter int NUM_CS = 4,
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0]        offset,
    input  logic                     in_window,
    input  logic [NUM_CS-1:0]        seg_valid,
    input  logic [NUM_CS*ADDR_W-1:0] lo_flat,
    input  logic [NUM_CS*ADDR_W-1:0] hi_flat,
    output logic [NUM_CS-1:0]        hit,
    output logic                     miss
);
    logic [NUM_CS-1:0] raw;

    for (genvar g = 0; g < NUM_CS; g++) begin : g_cmp
        assign raw[g] = in_window && seg_valid[g] &&
                        (offset >= lo_flat[g*ADDR_W +: ADDR_W]) &&
                        (offset <= hi_flat[g*ADDR_W +: ADDR_W]);
    end

    // Lowest-index priority: keep only the least significant set bit.
    assign hit  = raw & (~raw + NUM_CS'(1));
    assign miss = (raw == '0);
endmodule

// File: rtl/flash_seg_decoder.sv
module flash_seg_decoder #(
    parameter int ADDR_W     = flash_seg_pkg::DEF_ADDR_W,
    parameter int UNIT_SHIFT = flash_seg_pkg::DEF_UNIT_SHIFT,
    parameter int NUM_CS     = flash_seg_pkg::DEF_NUM_CS,
    parameter logic [ADDR_W-1:0] FLASH_BASE = 32'h2000_0000,
    parameter logic [ADDR_W:0]   WIN_BYTES  = 33'h0_1000_0000,
    parameter int RST_UNITS  = 2048,
    parameter int RST_SEGS   = 2,
    localparam int FIELD_W   = ADDR_W - UNIT_SHIFT,
    localparam int REG_W     = 2 * FIELD_W,
    localparam int SIZE_W    = ADDR_W + 1,
    localparam int IDX_W     = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     reg_wr_en,
    input  logic [IDX_W-1:0]         reg_wr_idx,
    input  logic [REG_W-1:0]         reg_wr_data,
    input  logic [IDX_W-1:0]         reg_rd_idx,
    output logic [REG_W-1:0]         reg_rd_data,
    input  logic [ADDR_W-1:0]        bus_addr,
    output logic [NUM_CS-1:0]        cs_hit,
    output logic                     cs_miss,
    output logic [NUM_CS*ADDR_W-1:0] win_base,
    output logic [NUM_CS*SIZE_W-1:0] win_size
);
    logic [NUM_CS*REG_W-1:0]  regs_flat;
    logic [NUM_CS-1:0]        seg_valid;
    logic [NUM_CS*ADDR_W-1:0] lo_flat;
    logic [NUM_CS*ADDR_W-1:0] hi_flat;
    logic [ADDR_W-1:0]        offset;
    logic                     in_window;

    seg_reg_file #(
        .NUM_CS    (NUM_CS),
        .FIELD_W   (FIELD_W),
        .RST_UNITS (RST_UNITS),
        .RST_SEGS  (RST_SEGS)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr_en),
        .wr_idx    (reg_wr_idx),
        .wr_data   (reg_wr_data),
        .rd_idx    (reg_rd_idx),
        .rd_data   (reg_rd_data),
        .regs_flat (regs_flat)
    );

    for (genvar g = 0; g < NUM_CS; g++) begin : g_win
        seg_window_calc #(
            .ADDR_W     (ADDR_W),
            .UNIT_SHIFT (UNIT_SHIFT),
            .FLASH_BASE (FLASH_BASE)
        ) u_calc (
            .seg_word  (regs_flat[g*REG_W +: REG_W]),
            .seg_valid (seg_valid[g]),
            .lo_off    (lo_flat[g*ADDR_W +: ADDR_W]),
            .hi_off    (hi_flat[g*ADDR_W +: ADDR_W]),
            .abs_base  (win_base[g*ADDR_W +: ADDR_W]),
            .byte_size (win_size[g*SIZE_W +: SIZE_W])
        );
    end

    assign offset    = bus_addr - FLASH_BASE;
    assign in_window = (bus_addr >= FLASH_BASE) && ({1'b0, offset} < WIN_BYTES);

    seg_hit_select #(
        .NUM_CS (NUM_CS),
        .ADDR_W (ADDR_W)
    ) u_sel (
        .offset    (offset),
        .in_window (in_window),
        .seg_valid (seg_valid),
        .lo_flat   (lo_flat),
        .hi_flat   (hi_flat),
        .hit       (cs_hit),
        .miss      (cs_miss)
    );
endmodule

// File: rtl/flash_seg_decoder_chk.sv
module flash_seg_decoder_chk #(
    parameter int NUM_CS = 4,
    parameter int ADDR_W = 32,
    parameter int REG_W  = 32,
    parameter int IDX_W  = 2,
    parameter logic [ADDR_W-1:0] FLASH_BASE = 32'h2000_0000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr_en,
    input logic [IDX_W-1:0]  reg_wr_idx,
    input logic [REG_W-1:0]  reg_wr_data,
    input logic [IDX_W-1:0]  reg_rd_idx,
    input logic [REG_W-1:0]  reg_rd_data,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [NUM_CS-1:0] cs_hit,
    input logic              cs_miss
);
    // R5
    hit_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cs_hit));

    // R6
    miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_miss |-> (cs_hit == '0));

    // R6
    hit_when_no_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_miss |-> ($countones(cs_hit) == 1));

    // R6
    below_base_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr < FLASH_BASE) |-> cs_miss);

    // R7
    wr_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(reg_wr_en) && (reg_rd_idx == $past(reg_wr_idx)))
        |-> (reg_rd_data == $past(reg_wr_data)));

    // R3
    zero_disables_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(reg_wr_en) && ($past(reg_wr_data) == '0))
        |-> (cs_hit[$past(reg_wr_idx)] == 1'b0));
endmodule

bind flash_seg_decoder flash_seg_decoder_chk #(
    .NUM_CS     (NUM_CS),
    .ADDR_W     (ADDR_W),
    .REG_W      (REG_W),
    .IDX_W      (IDX_W),
    .FLASH_BASE (FLASH_BASE)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr_en   (reg_wr_en),
    .reg_wr_idx  (reg_wr_idx),
    .reg_wr_data (reg_wr_data),
    .reg_rd_idx  (reg_rd_idx),
    .reg_rd_data (reg_rd_data),
    .bus_addr    (bus_addr),
    .cs_hit      (cs_hit),
    .cs_miss     (cs_miss)
);

// File: tb/flash_seg_decoder_bench.sv
module flash_seg_decoder_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_wr_en = 1'b0;
    logic [1:0]   reg_wr_idx = '0;
    logic [31:0]  reg_wr_data = '0;
    logic [1:0]   reg_rd_idx = '0;
    logic [31:0]  reg_rd_data;
    logic [31:0]  bus_addr = '0;
    logic [3:0]   cs_hit;
    logic         cs_miss;
    logic [127:0] win_base;
    logic [131:0] win_size;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    flash_seg_decoder u_flash_seg_decoder (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_wr_idx(reg_wr_idx), .reg_wr_data(reg_wr_data),
        .reg_rd_idx(reg_rd_idx), .reg_rd_data(reg_rd_data),
        .bus_addr(bus_addr), .cs_hit(cs_hit), .cs_miss(cs_miss),
        .win_base(win_base), .win_size(win_size)
    );

    // {address, expected hit, expected miss} with reset register contents
    localparam logic [36:0] VEC [8] = '{
        {32'h2000_0000, 4'b0001, 1'b0},
        {32'h27FF_FFFF, 4'b0001, 1'b0},
        {32'h2400_1234, 4'b0001, 1'b0},
        {32'h2800_0000, 4'b0010, 1'b0},
        {32'h2C00_0000, 4'b0010, 1'b0},
        {32'h2FFF_FFFF, 4'b0010, 1'b0},
        {32'h3000_0000, 4'b0000, 1'b1},
        {32'h1FFF_FFFF, 4'b0000, 1'b1}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic probe(input string req, input logic [31:0] a,
                         input logic [3:0] hit, input logic miss);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(req, {59'd0, cs_hit, cs_miss}, {59'd0, hit, miss});
    endtask

    task automatic write_seg(input logic [1:0] idx, input logic [31:0] val);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_idx = idx; reg_wr_data = val;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic read_seg(input string req, input logic [1:0] idx, input logic [31:0] exp);
        reg_rd_idx = idx;
        #1;
        check(req, {32'd0, reg_rd_data}, {32'd0, exp});
    endtask

    task automatic check_win(input string req, input int i,
                             input logic [31:0] b, input logic [32:0] s);
        check(req, {32'd0, win_base[i*32 +: 32]}, {32'd0, b});
        check(req, {31'd0, win_size[i*33 +: 33]}, {31'd0, s});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset contents
        read_seg("R1", 2'd0, 32'h07FF_0000);
        read_seg("R1", 2'd1, 32'h0FFF_0800);
        read_seg("R1", 2'd2, 32'h0000_0000);
        read_seg("R1", 2'd3, 32'h0000_0000);
        // R4 reset windows, R3 disabled windows
        check_win("R4", 0, 32'h2000_0000, 33'h0_0800_0000);
        check_win("R4", 1, 32'h2800_0000, 33'h0_0800_0000);
        check_win("R3", 2, 32'h2000_0000, 33'h0);
        check_win("R3", 3, 32'h2000_0000, 33'h0);

        // R2/R6 table walk over reset layout
        for (int k = 0; k < 8; k++) begin
            probe("R2_R6", VEC[k][36:5], VEC[k][4:1], VEC[k][0]);
        end

        // R5 overlap: cs2 over part of cs1, cs1 wins
        write_seg(2'd2, 32'h0C00_0A00);
        read_seg("R7", 2'd2, 32'h0C00_0A00);
        probe("R5", 32'h2A00_0000, 4'b0010, 1'b0);
        check_win("R4", 2, 32'h2A00_0000, 33'h0_0201_0000);

        // R3 disable cs1: cs2 now claims it
        write_seg(2'd1, 32'h0);
        probe("R3", 32'h2A00_0000, 4'b0100, 1'b0);
        check_win("R3", 1, 32'h2000_0000, 33'h0);
        probe("R3", 32'h2900_0000, 4'b0000, 1'b1);

        // R2 inclusive end boundaries
        probe("R2", 32'h2C00_FFFF, 4'b0100, 1'b0);
        probe("R2", 32'h2C01_0000, 4'b0000, 1'b1);
        probe("R2", 32'h29FF_FFFF, 4'b0000, 1'b1);

        // R8 inverted register
        write_seg(2'd0, 32'h0);
        write_seg(2'd3, 32'h0100_0200);
        probe("R8", 32'h2100_0000, 4'b0000, 1'b1);
        probe("R8", 32'h2200_0000, 4'b0000, 1'b1);
        check_win("R8", 3, 32'h2200_0000, 33'h0);

        // R7 write and decode in the same cycle
        @(negedge clk);
        reg_rd_idx = 2'd0;
        bus_addr = 32'h2000_0000;
        reg_wr_en = 1'b1; reg_wr_idx = 2'd0; reg_wr_data = 32'h00FF_0000;
        #1;
        check("R7", {59'd0, cs_hit, cs_miss}, {59'd0, 4'b0000, 1'b1});
        check("R7", {32'd0, reg_rd_data}, 64'd0);
        @(negedge clk);
        reg_wr_en = 1'b0;
        #1;
        check("R7", {59'd0, cs_hit, cs_miss}, {59'd0, 4'b0001, 1'b0});
        check("R7", {32'd0, reg_rd_data}, 64'h00FF_0000);
        probe("R2", 32'h20FF_FFFF, 4'b0001, 1'b0);
        probe("R6", 32'h2100_0000, 4'b0000, 1'b1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule